// File: doc/BRIEF.md
# Three-Word Memory-to-Memory Processor Core

This core runs programs in which every instruction is three consecutive words in one shared memory: the address of a first operand, the address of a second operand, and a signed jump offset. There is no accumulator. The core reads both operands, combines them in one of four ways, and writes the result over the second operand. Only a subtraction that gives a negative result moves the program counter by the offset. Every other case steps past the three words.

The core advances only on clock edges where the clock enable is high. The enable is meant to run at half the input clock rate. The core drives address, write strobe and write data to an external synchronous single-port memory of 12-bit words. A read returns the word one enabled edge after its address was presented. A synchronous reset loads the program counter from a start address. Each instruction takes nine enabled steps, 0 to 8. Bit 11 of the first two words of an instruction selects the operation.

Top module: `mm_proc`

## Requirements
- R1: While reset is high, and on the first enabled step after it, `mem_addr` equals `start_pc` and `mem_we` is low.
- R2: Each instruction takes nine enabled steps and writes memory exactly once. With the enable high on every other clock, successive write-backs are 18 clocks apart.
- R3: For an instruction at address p, the addresses presented on steps 0, 1, 3, 4, 6 and 7 are, in that order: p, the operand-A address (word p bits 10:0), p+1, the operand-B address (word p+1 bits 10:0), the operand-B address again with `mem_we` high, and p+2. `mem_we` is low on every other step.
- R4: Opcode 00 writes (B − A) mod 2^11 to B's address, for example 0x000 − 0x001 = 0x7FF. Bit 11 of every word written is 0.
- R5: If opcode 00 gives a result with bit 10 set, the next instruction starts at (p + 2 + offset) mod 2^11. The offset is word p+2 bits 10:0 as read after the write-back.
- R6: If opcode 00 gives a non-negative result, or for any other opcode, the next instruction starts at (p + 3) mod 2^11.
- R7: Opcode 01 writes the GF(2^8) product of the low bytes of A and B, reduced by x^8+x^4+x^3+x^2+1 and zero-extended, for example 0x53 · 0xF8 = 0xC2.
- R8: Opcode 10 writes B XOR A over 11 bits.
- R9: Opcode 11 writes a value with bit 7 = B bit 10, bits 6:0 = B bits 6:0, and bits 10:8 = 0, for example 0x7F8 → 0x0F8.
- R10: The opcode is {word p bit 11, word p+1 bit 11}.
- R11: While the enable is low, the outputs and all internal state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| ce | input | 1 | Step enable, nominally half rate |
| rst | input | 1 | Synchronous reset, active high |
| start_pc | input | 11 | Program counter value loaded by reset |
| mem_addr | output | 11 | Memory address |
| mem_we | output | 1 | Memory write strobe (step 6) |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, one enabled edge after its address |

## Verification
On step 6 the write-back of the result and the fetch of the jump offset fall together: the offset word is read on the very next step, and the branch decision was taken in the same step as the result. The bench provokes this with an instruction whose operand B is its own offset word. The negative result is written there and then taken as the jump distance. The bench judges it by the address of the next write-back, which an independent instruction-level model of the program predicts. A freeze of the enable in the middle of the program then checks that nothing moves and that the sequence resumes intact.

// File: rtl/mm_proc.sv
module mm_proc #(
  parameter int AW   = 11,
  parameter int GFW  = 8,
  parameter int POLY = 'h11D
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          rst,
  input  logic [AW-1:0] start_pc,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [AW:0]   mem_wdata,
  input  logic [AW:0]   mem_rdata
);
  localparam int NW = 8;
  localparam logic [GFW-1:0] RED = GFW'(POLY);

  logic [3:0]    step;
  logic [AW-1:0] pc, opa, baddr, mdr, res;
  logic [1:0]    op;
  logic          neg;
  wire  [AW-1:0] rd = mem_rdata[AW-1:0];

  function automatic logic [GFW-1:0] gf_mul(input logic [GFW-1:0] x, input logic [GFW-1:0] y);
    logic [GFW-1:0] acc, sh;
    acc = '0;
    sh  = x;
    for (int i = 0; i < GFW; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh[GFW-1] ? ((sh << 1) ^ RED) : (sh << 1);
    end
    return acc;
  endfunction

  always_comb begin
    case (op)
      2'b00:   res = rd - opa;
      2'b01:   res = AW'(gf_mul(opa[GFW-1:0], rd[GFW-1:0]));
      2'b10:   res = rd ^ opa;
      default: res = {{(AW-NW){1'b0}}, rd[AW-1], rd[NW-2:0]};
    endcase
  end

  always_comb begin
    case (step)
      4'd1, 4'd4: mem_addr = rd;
      4'd6:       mem_addr = baddr;
      4'd7:       mem_addr = pc + AW'(1);
      default:    mem_addr = pc;
    endcase
  end

  assign mem_we    = (step == 4'd6);
  assign mem_wdata = {1'b0, mdr};

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= '0;
      pc    <= start_pc;
      opa   <= '0;
      baddr <= '0;
      mdr   <= '0;
      op    <= '0;
      neg   <= 1'b0;
    end else if (ce) begin
      step <= (step == 4'd8) ? 4'd0 : step + 4'd1;
      case (step)
        4'd0: pc <= pc + AW'(1);
        4'd1: op[1] <= mem_rdata[AW];
        4'd2: opa <= rd;
        4'd4: begin
          op[0] <= mem_rdata[AW];
          baddr <= rd;
        end
        4'd5: begin
          mdr <= res;
          neg <= (op == 2'b00) && res[AW-1];
        end
        4'd8: pc <= pc + (neg ? rd : AW'(1)) + AW'(1);
        default: ;
      endcase
    end
  end

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (rst) step <= 4'd8);
  // R2
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst) (ce && step == 4'd8) |=> step == 4'd0);
  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (rst) !ce |=> ($stable(pc) && $stable(step) && $stable(mdr)));
  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && step != 4'd0 && step != 4'd8) |=> $stable(pc));
  // R4
  wdata_top_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> !mem_wdata[AW]);
  // R9
  narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (step == 4'd6 && op == 2'b11) |-> mdr[AW-1:NW] == '0);
endmodule

// File: tb/tb_mm_proc.sv
module tb_mm_proc;
  localparam int AW = 11;
  localparam int NINS = 14;
  localparam logic [AW-1:0] START = 11'h010;

  logic clk = 0, ce = 0, rst = 1, freeze = 0, freeze_seen = 0;
  logic [AW-1:0] mem_addr;
  logic mem_we;
  logic [AW:0] mem_wdata, mem_rdata;
  logic [AW:0] mem [0:2047];
  logic [AW:0] sm  [0:2047];

  int compared = 0, mismatched = 0, seen = 0, cyc = 0, last_wr = -1, en_idx = 0;
  int q_addr[$], q_data[$];
  string q_tag[$];

  always #4 clk = ~clk;

  mm_proc dut (.clk(clk), .ce(ce), .rst(rst), .start_pc(START), .mem_addr(mem_addr),
               .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) if (ce) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  initial forever begin
    @(posedge clk);
    #2 ce = freeze ? 1'b0 : ~ce;
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int gf_ref(input int x, input int y);
    int p = 0;
    for (int i = 0; i < 8; i++) if (y[i]) p ^= (x << i);
    for (int k = 14; k >= 8; k--) if (p[k]) p ^= ('h11D << (k - 8));
    return p;
  endfunction

  task automatic run_model();
    int p = START;
    bit branched = 0;
    for (int n = 0; n < NINS; n++) begin
      int w0, w1, a, b, r, ba, off;
      string tag;
      w0 = sm[p]; w1 = sm[(p + 1) % 2048];
      ba = w1 & 'h7FF;
      a = sm[w0 & 'h7FF] & 'h7FF; b = sm[ba] & 'h7FF;
      case ({w0[11], w1[11]})
        2'b00: begin r = (b - a) & 'h7FF; tag = "R4"; end
        2'b01: begin r = gf_ref(a & 'hFF, b & 'hFF); tag = "R7 R10"; end
        2'b10: begin r = (a ^ b) & 'h7FF; tag = "R8 R10"; end
        default: begin r = (((b >> 10) & 1) << 7) | (b & 'h7F); tag = "R9 R10"; end
      endcase
      if (n > 0) tag = {tag, branched ? " R5" : " R6"};
      sm[ba] = r[11:0];
      q_addr.push_back(ba); q_data.push_back(r); q_tag.push_back(tag);
      off = sm[(p + 2) % 2048] & 'h7FF;
      branched = ({w0[11], w1[11]} == 2'b00) && r[10];
      p = branched ? (p + 2 + off) % 2048 : (p + 3) % 2048;
    end
  endtask

  // monitor: samples half a cycle before the edge that acts on it
  always @(negedge clk) begin
    cyc++;
    if (!rst && ce) begin
      if (en_idx < 9) begin
        case (en_idx)
          0: check("R3 step0", mem_addr, 'h010);
          1: check("R3 step1", mem_addr, 'h100);
          3: check("R3 step3", mem_addr, 'h011);
          4: check("R3 step4", mem_addr, 'h101);
          6: check("R3 step6", mem_addr, 'h101);
          7: check("R3 step7", mem_addr, 'h012);
          default: ;
        endcase
        check("R3 strobe", mem_we, en_idx == 6);
        en_idx++;
      end
      if (mem_we && seen < NINS) begin
        string t;
        t = q_tag.pop_front();
        check({t, " addr"}, mem_addr, q_addr.pop_front());
        check({t, " data"}, mem_wdata, q_data.pop_front());
        if (last_wr >= 0 && !freeze_seen) check("R2 spacing", cyc - last_wr, 18);
        freeze_seen = 0;
        last_wr = cyc;
        seen++;
      end
    end
  end

  initial begin
    logic [AW-1:0] held_addr;
    logic held_we;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem['h010] = 'h100; mem['h011] = 'h101; mem['h012] = 'h004;
    mem['h016] = 'h102; mem['h017] = 'h903; mem['h018] = 'h000;
    mem['h019] = 'h904; mem['h01A] = 'h105; mem['h01B] = 'h000;
    mem['h01C] = 'h904; mem['h01D] = 'h905; mem['h01E] = 'h000;
    mem['h01F] = 'h106; mem['h020] = 'h107; mem['h021] = 'h001;
    mem['h022] = 'h108; mem['h023] = 'h024; mem['h024] = 'h002;
    mem['h100] = 'h001; mem['h101] = 'h000; mem['h102] = 'h053; mem['h103] = 'h0F8;
    mem['h104] = 'h7F8; mem['h105] = 'h000; mem['h106] = 'h003; mem['h107] = 'h005;
    mem['h108] = 'h00A;
    for (int i = 0; i < 2048; i++) sm[i] = mem[i];
    run_model();
    // fixed examples from the requirements
    check("R4 example", q_data[0], 'h7FF);
    check("R5 example target", q_addr[1], 'h103);
    check("R7 example", q_data[1], 'h0C2);
    check("R9 example", q_data[3], 'h0F8);

    repeat (3) @(negedge clk);
    check("R1 addr in reset", mem_addr, START);
    check("R1 strobe in reset", mem_we, 0);
    @(posedge clk); #1 rst = 0;

    wait (seen >= 5);
    @(negedge clk); freeze = 1;
    repeat (2) @(negedge clk);
    held_addr = mem_addr; held_we = mem_we;
    repeat (20) @(negedge clk);
    check("R11 addr held", mem_addr, held_addr);
    check("R11 strobe held", mem_we, held_we);
    freeze_seen = 1; freeze = 0;

    for (int i = 0; i < 20000 && seen < NINS; i++) @(posedge clk);
    if (seen < NINS) begin
      compared++; mismatched++;
      $display("FAIL R2: watchdog, actual %0d write-backs expected %0d", seen, NINS);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule